// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous static memory that keeps its data bus busy on every cycle, whatever mix of reads and writes arrives. A command is registered on a rising clock edge. Read data for that command appears in the cycle that follows the edge, fed straight from the array with no output register. Write data is taken one enabled edge after its address, which lines up with the read timing, so a read may follow a write with no idle cycle.

Each access can run as a four-beat burst. The low two address bits come from an internal counter, which steps in either linear or interleaved order. An active-low clock enable stalls the whole block. Three chip selects and an address-advance input choose between starting an access, continuing a burst, and deselecting. A real tristate pin is replaced by separate data-in, data-out and drive-enable ports. The array is split into byte lanes, and each lane has its own write enable.

Top module: `flowthru_sram`

## Requirements
- R1: After reset the block is deselected: `dout_en` is 0 and `dout` is all zeros, whatever the state of `oe_n`.
- R2: On an edge where `cke_n` is 1, every register keeps its value: the burst does not advance, the current address stays the same, and a pending write is not committed. A pending write takes the `din` value present at the next edge where `cke_n` is 0.
- R3: A read starts when, at an edge, `cke_n`=0, `adv`=0, `cs1_n`=0, `cs2`=1, `cs3_n`=0 and `we_n`=1. In the cycle that follows that edge, `dout` shows the word at `addr`.
- R4: `oe_n` is asynchronous. `dout_en` is 1 only during a read cycle with `oe_n` low. Whenever `dout_en` is 0, `dout` is all zeros.
- R5: A write starts under the same select conditions with `we_n`=0. The word on `din` at the next enabled edge is stored at the registered address.
- R6: Byte lane i is bits [9i+8:9i]. Lane i is written only when `bw_n[i]`=0 for that beat. A write beat with all `bw_n` bits high changes no location.
- R7: With `adv`=1 during an active access, the next enabled edge moves to the next burst address and keeps the read or write direction of the access. Each write beat uses its own `bw_n`. An aborted beat still advances the burst.
- R8: With `ilv_sel`=0, the low two address bits go start, start+1, start+2, start+3 (modulo 4). After four beats they return to start.
- R9: With `ilv_sel`=1, the low two address bits on beat n are start XOR n.
- R10: `adv`=0 with any chip select inactive deselects the block. `adv`=1 while deselected keeps it deselected. Nothing is driven and nothing is written while deselected.
- R11: A read issued on the edge right after a write edge to the same address returns the new write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new command, 1 continues the burst or the deselect |
| we_n | input | 1 | 1 read, 0 write |
| bw_n | input | LANES | Active-low byte lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| ilv_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, one enabled edge after the address |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | High when the data bus would be driven |

## Verification
A wrong burst counter or a wrong stored start value shows at `dout` in the first beat where the low address bits differ. This is visible in the cycle after the advancing edge, because the read is combinational from the registered address. A late-write stage that commits on the wrong edge, or with the wrong lane mask, shows only when the affected address is read back. For that reason the bench reads every location it has touched and compares the result with a behavioural model of the array. A missed stall or deselect shows at once as a change in `dout_en` or in the address being read.

// File: rtl/flowthru_pkg.sv
package flowthru_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/ft_burst_step.sv
module ft_burst_step #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] beat,
    input  logic             interleave,
    output logic [CNT_W-1:0] low_addr
);
    always_comb begin
        if (interleave) low_addr = start ^ beat;
        else            low_addr = start + beat;
    end
endmodule

// File: rtl/ft_lane_array.sv
module ft_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          wr_lane,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_lane[l]) cells[addr] <= wdata[l*LANE_W +: LANE_W];
        end
        assign rdata[l*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/flowthru_sram.sv
module flowthru_sram
    import flowthru_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke_n,
    input  logic                     cs1_n,
    input  logic                     cs2,
    input  logic                     cs3_n,
    input  logic                     adv,
    input  logic                     we_n,
    input  logic [LANES-1:0]         bw_n,
    input  logic                     oe_n,
    input  logic                     ilv_sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  din,
    output logic [LANES*LANE_W-1:0]  dout,
    output logic                     dout_en
);
    localparam int CNT_W  = 2;
    localparam int HI_W   = ADDR_W - CNT_W;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e              op;
        logic [HI_W-1:0]  hi;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] cnt;
        logic [LANES-1:0] bw;
    } state_t;

    state_t st_d, st_q;
    logic [LANES-1:0]  commit_d;
    logic              sel;
    logic [CNT_W-1:0]  low_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rdata;

    assign sel = !cs1_n && cs2 && !cs3_n;

    ft_burst_step #(.CNT_W(CNT_W)) u_step (
        .start      (st_q.start),
        .beat       (st_q.cnt),
        .interleave (ilv_sel),
        .low_addr   (low_q)
    );

    assign cur_addr = {st_q.hi, low_q};

    always_comb begin
        st_d     = st_q;
        commit_d = '0;
        if (!cke_n) begin
            if (st_q.op == OP_WRITE) commit_d = st_q.bw;
            if (!adv) begin
                if (sel) begin
                    st_d.op    = we_n ? OP_READ : OP_WRITE;
                    st_d.hi    = addr[ADDR_W-1:CNT_W];
                    st_d.start = addr[CNT_W-1:0];
                    st_d.cnt   = '0;
                    st_d.bw    = we_n ? '0 : ~bw_n;
                end else begin
                    st_d.op = OP_IDLE;
                    st_d.bw = '0;
                end
            end else if (st_q.op != OP_IDLE) begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.bw  = (st_q.op == OP_WRITE) ? ~bw_n : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ft_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_lane (commit_d),
        .addr    (cur_addr),
        .wdata   (din),
        .rdata   (rdata)
    );

    assign dout_en = (st_q.op == OP_READ) && !oe_n;
    assign dout    = dout_en ? rdata : '0;

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(st_q));
    // R3
    read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && sel && we_n) |=> (st_q.op == OP_READ));
    // R6
    abort_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && sel && !we_n && (&bw_n)) |=> (st_q.bw == '0));
    // R7
    burst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && st_q.op != OP_IDLE) |=> (st_q.op == $past(st_q.op)));
    // R8
    burst_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && st_q.op != OP_IDLE) |=> (st_q.cnt == $past(st_q.cnt) + 2'd1));
    // R10
    desel_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && adv && st_q.op == OP_IDLE) |=> (st_q.op == OP_IDLE));
    // R10
    desel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !adv && !sel) |=> (st_q.op == OP_IDLE && !dout_en));
endmodule

// File: tb/flowthru_sram_tb.sv
`timescale 1ns/1ps
module flowthru_sram_tb;
    localparam int AW = 8;
    localparam int DW = 18;
    localparam logic [2:0] SEL = 3'b010;

    logic clk = 0;
    logic rst_n = 0;
    logic cke_n = 0, cs1_n = 1, cs2 = 0, cs3_n = 1, adv = 0, we_n = 1, oe_n = 0, ilv_sel = 0;
    logic [1:0] bw_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en;

    int n_chk = 0, n_fail = 0;

    logic [DW-1:0] mmem [256];
    int m_op = 0;
    logic [AW-1:0] m_addr = '0;
    logic [1:0] m_start = '0, m_cnt = '0, m_bw = '0;

    always #5 clk = ~clk;

    flowthru_sram u_dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .adv(adv), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n), .ilv_sel(ilv_sel),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out(input string tag);
        logic exp_en;
        exp_en = (m_op == 1) && !oe_n;
        chk(tag, {17'd0, dout_en}, {17'd0, exp_en});
        chk(tag, dout, exp_en ? mmem[m_addr] : '0);
    endtask

    task automatic cyc(input logic ck, input logic [2:0] cs, input logic a, input logic w,
                       input logic [1:0] b, input logic [AW-1:0] ad, input logic [DW-1:0] d,
                       input string tag);
        cke_n = ck; {cs1_n, cs2, cs3_n} = cs; adv = a; we_n = w; bw_n = b; addr = ad; din = d;
        @(posedge clk);
        if (!ck) begin
            if (m_op == 2) begin
                if (m_bw[0]) mmem[m_addr][8:0]  = d[8:0];
                if (m_bw[1]) mmem[m_addr][17:9] = d[17:9];
            end
            if (!a) begin
                if (cs == SEL) begin
                    m_op = w ? 1 : 2; m_addr = ad; m_start = ad[1:0]; m_cnt = 0; m_bw = ~b;
                end else m_op = 0;
            end else if (m_op != 0) begin
                m_cnt = m_cnt + 1;
                m_addr[1:0] = ilv_sel ? (m_start ^ m_cnt) : (m_start + m_cnt);
                m_bw = ~b;
            end
        end
        #1;
        check_out(tag);
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'((i * 1237 + 91) ^ (i << 9));
    endfunction

    task automatic t_reset();
        oe_n = 0; #1;
        chk("R1 dout_en after reset", {17'd0, dout_en}, 18'd0);
        chk("R1 dout after reset", dout, 18'd0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 256; i++)
            cyc(0, SEL, 0, 0, 2'b00, AW'(i), (i == 0) ? 18'd0 : pat(i - 1), "R5 fill");
        cyc(0, 3'b110, 0, 1, 2'b11, 8'd0, pat(255), "R5 fill last");
    endtask

    task automatic t_reads();
        cyc(0, SEL, 0, 1, 2'b11, 8'd7, 18'd0, "R3 read 7");
        chk("R3 read value", dout, pat(7));
        oe_n = 1; #1;
        chk("R4 oe high disables", {17'd0, dout_en}, 18'd0);
        chk("R4 oe high zero dout", dout, 18'd0);
        oe_n = 0; #1;
        chk("R4 oe low re-drives", dout, pat(7));
        cyc(0, SEL, 0, 1, 2'b11, 8'd200, 18'd0, "R3 read 200");
        cyc(0, SEL, 0, 1, 2'b11, 8'd255, 18'd0, "R3 read 255");
    endtask

    task automatic t_b2b();
        cyc(0, SEL, 0, 0, 2'b00, 8'd10, 18'd0, "R11 write 10");
        cyc(0, SEL, 0, 1, 2'b11, 8'd10, 18'h2AAAA, "R11 read 10");
        chk("R11 fresh data", dout, 18'h2AAAA);
        cyc(0, SEL, 0, 0, 2'b00, 8'd11, 18'd0, "R11 write 11");
        cyc(0, SEL, 0, 1, 2'b11, 8'd10, 18'h01234, "R11 read other");
        cyc(0, SEL, 0, 1, 2'b11, 8'd11, 18'd0, "R11 read 11");
        chk("R11 second data", dout, 18'h01234);
    endtask

    task automatic t_bytes();
        logic [DW-1:0] old22;
        old22 = mmem[22];
        cyc(0, SEL, 0, 0, 2'b10, 8'd20, 18'd0, "R6 lane0 write");
        cyc(0, SEL, 0, 0, 2'b01, 8'd21, 18'h3FFFF, "R6 lane1 write");
        cyc(0, SEL, 0, 0, 2'b11, 8'd22, 18'h15555, "R6 abort");
        cyc(0, 3'b110, 0, 1, 2'b11, 8'd0, 18'h0ABCD, "R6 idle");
        cyc(0, SEL, 0, 1, 2'b11, 8'd20, 18'd0, "R6 read 20");
        chk("R6 lane0 only", dout, {pat(20)[17:9], 9'h1FF});
        cyc(0, SEL, 0, 1, 2'b11, 8'd21, 18'd0, "R6 read 21");
        chk("R6 lane1 only", dout, {9'h0AA, pat(21)[8:0]});
        cyc(0, SEL, 0, 1, 2'b11, 8'd22, 18'd0, "R6 read 22");
        chk("R6 abort unchanged", dout, old22);
    endtask

    task automatic t_burst_lin();
        ilv_sel = 0;
        cyc(0, SEL, 0, 1, 2'b11, 8'h41, 18'd0, "R8 start");
        for (int k = 1; k <= 4; k++) cyc(0, SEL, 1, 1, 2'b11, 8'h00, 18'd0, "R8 beat");
        chk("R8 wrapped to start", dout, mmem[8'h41]);
        cyc(0, SEL, 0, 0, 2'b00, 8'h81, 18'd0, "R7 wburst start");
        cyc(0, SEL, 1, 1, 2'b11, 8'h00, 18'h11111, "R7 wbeat abort");
        cyc(0, SEL, 1, 1, 2'b00, 8'h00, 18'h22222, "R7 wbeat");
        cyc(0, SEL, 1, 1, 2'b00, 8'h00, 18'h33333, "R7 wbeat");
        cyc(0, 3'b000, 0, 1, 2'b11, 8'h00, 18'h04444, "R7 wburst end");
        cyc(0, SEL, 0, 1, 2'b11, 8'h80, 18'd0, "R7 read 80");
        chk("R7 beat4 at 80", dout, 18'h04444);
        cyc(0, SEL, 0, 1, 2'b11, 8'h83, 18'd0, "R7 read 83");
        chk("R7 beat3 at 83", dout, 18'h33333);
        cyc(0, SEL, 0, 1, 2'b11, 8'h82, 18'd0, "R7 read 82");
        chk("R7 aborted beat kept", dout, pat(8'h82));
        cyc(0, SEL, 0, 1, 2'b11, 8'h81, 18'd0, "R7 read 81");
        chk("R7 beat1 at 81", dout, 18'h11111);
    endtask

    task automatic t_burst_ilv();
        cyc(0, 3'b110, 0, 1, 2'b11, 8'h00, 18'd0, "R9 idle");
        ilv_sel = 1;
        cyc(0, SEL, 0, 1, 2'b11, 8'h62, 18'd0, "R9 start 62");
        cyc(0, SEL, 1, 1, 2'b11, 8'h00, 18'd0, "R9 beat");
        chk("R9 beat1 63", dout, mmem[8'h63]);
        cyc(0, SEL, 1, 1, 2'b11, 8'h00, 18'd0, "R9 beat");
        chk("R9 beat2 60", dout, mmem[8'h60]);
        cyc(0, SEL, 1, 1, 2'b11, 8'h00, 18'd0, "R9 beat");
        chk("R9 beat3 61", dout, mmem[8'h61]);
        cyc(0, SEL, 0, 1, 2'b11, 8'h71, 18'd0, "R9 start 71");
        cyc(0, SEL, 1, 1, 2'b11, 8'h00, 18'd0, "R9 beat");
        chk("R9 beat1 70", dout, mmem[8'h70]);
        cyc(0, SEL, 1, 1, 2'b11, 8'h00, 18'd0, "R9 beat");
        chk("R9 beat2 73", dout, mmem[8'h73]);
        cyc(0, 3'b110, 0, 1, 2'b11, 8'h00, 18'd0, "R9 idle");
        ilv_sel = 0;
    endtask

    task automatic t_cke();
        cyc(0, SEL, 0, 1, 2'b11, 8'h30, 18'd0, "R2 read 30");
        cyc(1, 3'b110, 1, 0, 2'b00, 8'h99, 18'd0, "R2 stall");
        cyc(1, SEL, 0, 0, 2'b00, 8'h55, 18'd0, "R2 stall");
        chk("R2 address held", dout, pat(8'h30));
        cyc(0, SEL, 0, 0, 2'b00, 8'h31, 18'd0, "R2 write 31");
        cyc(1, SEL, 0, 1, 2'b11, 8'h31, 18'h3DEAD, "R2 stall on write");
        cyc(0, 3'b110, 0, 1, 2'b11, 8'h00, 18'h0BEEF, "R2 commit");
        cyc(0, SEL, 0, 1, 2'b11, 8'h31, 18'd0, "R2 read 31");
        chk("R2 data from enabled edge", dout, 18'h0BEEF);
    endtask

    task automatic t_desel();
        logic [DW-1:0] old50;
        old50 = mmem[8'h50];
        cyc(0, 3'b110, 0, 1, 2'b11, 8'h50, 18'd0, "R10 cs1 off");
        cyc(0, 3'b000, 0, 1, 2'b11, 8'h50, 18'd0, "R10 cs2 off");
        cyc(0, 3'b011, 0, 0, 2'b00, 8'h50, 18'd0, "R10 cs3 off write");
        cyc(0, SEL, 1, 0, 2'b00, 8'h50, 18'h3AAAA, "R10 continue deselect");
        cyc(0, SEL, 1, 1, 2'b00, 8'h50, 18'h3AAAA, "R10 continue deselect");
        chk("R10 not driven", {17'd0, dout_en}, 18'd0);
        cyc(0, SEL, 0, 1, 2'b11, 8'h50, 18'd0, "R10 read 50");
        chk("R10 no write while deselected", dout, old50);
    endtask

    task automatic t_mix(input logic ilv);
        cyc(0, 3'b110, 0, 1, 2'b11, 8'h00, 18'd0, "MIX idle");
        ilv_sel = ilv;
        for (int i = 0; i < 300; i++) begin
            logic ck, a, w;
            logic [2:0] cs;
            ck = ($urandom % 8) == 0;
            a  = ($urandom % 3) == 0;
            cs = (($urandom % 6) == 0) ? 3'($urandom) : SEL;
            w  = $urandom % 2;
            cyc(ck, cs, a, w, 2'($urandom), AW'($urandom), DW'($urandom), "MIX R2 R7 R10");
        end
        cyc(0, 3'b110, 0, 1, 2'b11, 8'h00, 18'd0, "MIX idle");
        ilv_sel = 0;
        for (int i = 0; i < 256; i++) cyc(0, SEL, 0, 1, 2'b11, AW'(i), 18'd0, "MIX readback R5 R6");
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        @(posedge clk); #1;
        t_reset();
        t_fill();
        t_reads();
        t_b2b();
        t_bytes();
        t_burst_lin();
        t_burst_ilv();
        t_cke();
        t_desel();
        t_mix(0);
        t_mix(1);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule